// File: doc/BRIEF.md
# Port Interrupt-On-Change Controller

This block raises interrupts for two input ports of `PW` pins each. Every pin has an enable bit and a compare-select bit. With the select bit at 0 the pin fires when its level differs from the level sampled on the previous clock. With the select bit at 1 it fires when its level differs from a programmed default bit. The first qualifying event on a port makes that port pending. At the same edge the block records which pins fired in a flag vector and stores the raw port level in a capture vector. Both vectors then hold their values until software acknowledges the event. The acknowledge strobe stands for a read of the port's capture or port register.

Two interrupt pins leave the block as an output value plus an output enable. Three configuration bits shape them. The merge bit ORs the two ports onto both pins. The level bit picks active-high or active-low drive. The open-drain bit reduces each pin to pull-low-or-float and takes precedence over the level bit. Pin levels come in already synchronised, and configuration comes from a register interface outside this block.

Top module: `pinchg_irq`

## Requirements
- R1: While reset is high, every flag and capture bit reads 0, and both interrupt pins float (`irq_*_oe` = 0, `irq_*_out` = 0).
- R2: An enabled pin whose compare-select bit is 0 and whose level differs from the level sampled one clock earlier makes its port pending and sets its flag bit.
- R3: An enabled pin whose compare-select bit is 1 fires while its level differs from its default bit. Because the mismatch persists, the pin fires again on the clock after an acknowledge.
- R4: A pin whose enable bit is 0 never sets a flag bit and never makes its port pending.
- R5: When a port becomes pending, its capture vector takes the raw pin levels of that same clock. Flag bits equal exactly the enabled mismatching pins of that clock.
- R6: While a port is pending and not acknowledged, further pin activity leaves its flag and capture vectors unchanged.
- R7: An acknowledge on a pending port clears its flags to 0 at the next edge and keeps its capture value. An acknowledge on a port that is not pending changes nothing.
- R8: With merge = 0, each interrupt pin follows only its own port, and an event on one port never alters the other port's flags.
- R9: With merge = 1, both interrupt pins show the OR of the two pending states.
- R10: With open-drain = 0, both pins are driven (`oe` = 1). `out` equals the pending state when the level bit is 1 and its inverse when the level bit is 0.
- R11: With open-drain = 1, `out` is 0 and `oe` equals the pending state, whatever the level bit.
- R12: Flag and capture change at the first clock edge that samples the causing pin level. The interrupt pins change one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | PW | Synchronised levels of port A |
| pin_b | input | PW | Synchronised levels of port B |
| ien_a | input | PW | Per-pin interrupt enable, port A |
| ien_b | input | PW | Per-pin interrupt enable, port B |
| dflt_a | input | PW | Default compare values, port A |
| dflt_b | input | PW | Default compare values, port B |
| cmpsel_a | input | PW | Compare select, port A (0 previous sample, 1 default) |
| cmpsel_b | input | PW | Compare select, port B |
| rd_ack_a | input | 1 | Acknowledge strobe (capture/port read), port A |
| rd_ack_b | input | 1 | Acknowledge strobe, port B |
| cfg_merge | input | 1 | 1 = both interrupt pins carry the OR of both ports |
| cfg_odrain | input | 1 | 1 = open-drain style pins |
| cfg_actlvl | input | 1 | Driven pin level when asserted (1 high, 0 low) |
| flag_a | output | PW | Pins that caused the pending event, port A |
| flag_b | output | PW | Pins that caused the pending event, port B |
| cap_a | output | PW | Port A levels captured at the event |
| cap_b | output | PW | Port B levels captured at the event |
| irq_a_out | output | 1 | Interrupt pin A output value |
| irq_a_oe | output | 1 | Interrupt pin A output enable |
| irq_b_out | output | 1 | Interrupt pin B output value |
| irq_b_oe | output | 1 | Interrupt pin B output enable |

## Verification
Flag and capture results appear one edge after the pin, enable or acknowledge change that causes them. The pin stage adds a second edge. The bench drives on the falling edge and reads flags and captures at the next falling edge. It reads the interrupt pins one falling edge later, and it also confirms they have not moved after the first edge. For the drive sweep the configuration and pending state are set up first, followed by three settling edges before the pins are compared, so no check falls inside the pipeline.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
  localparam int NPORT = 2;

  typedef struct packed {
    logic merge;
    logic odrain;
    logic actlvl;
  } drv_cfg_t;
endpackage

// File: rtl/pinchg_port.sv
module pinchg_port #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pin,
  input  logic [PW-1:0] ien,
  input  logic [PW-1:0] dflt,
  input  logic [PW-1:0] cmpsel,
  input  logic          ack,
  output logic          pend,
  output logic [PW-1:0] flag,
  output logic [PW-1:0] cap
);
  logic [PW-1:0] prev;
  logic [PW-1:0] hit;

  // per-pin compare: previous sample or programmed default
  for (genvar i = 0; i < PW; i++) begin : g_cmp
    assign hit[i] = ien[i] & (cmpsel[i] ? (pin[i] ^ dflt[i]) : (pin[i] ^ prev[i]));
  end

  always_ff @(posedge clk) begin
    prev <= pin;
    if (rst) begin
      pend <= 1'b0;
      flag <= '0;
      cap  <= '0;
    end else if (pend) begin
      if (ack) begin
        pend <= 1'b0;
        flag <= '0;
      end
    end else if (|hit) begin
      pend <= 1'b1;
      flag <= hit;
      cap  <= pin;
    end
  end
endmodule

// File: rtl/pinchg_drive.sv
module pinchg_drive #(
  parameter int NP = pinchg_pkg::NPORT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pinchg_pkg::drv_cfg_t cfg,
  input  logic [NP-1:0]        pend,
  output logic [NP-1:0]        out,
  output logic [NP-1:0]        oe
);
  logic [NP-1:0] act;
  logic          any_pend;

  assign any_pend = |pend;

  for (genvar p = 0; p < NP; p++) begin : g_pin
    assign act[p] = cfg.merge ? any_pend : pend[p];

    always_ff @(posedge clk) begin
      if (rst) begin
        out[p] <= 1'b0;
        oe[p]  <= 1'b0;
      end else if (cfg.odrain) begin
        out[p] <= 1'b0;
        oe[p]  <= act[p];
      end else begin
        out[p] <= cfg.actlvl ? act[p] : ~act[p];
        oe[p]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pin_a,
  input  logic [PW-1:0] pin_b,
  input  logic [PW-1:0] ien_a,
  input  logic [PW-1:0] ien_b,
  input  logic [PW-1:0] dflt_a,
  input  logic [PW-1:0] dflt_b,
  input  logic [PW-1:0] cmpsel_a,
  input  logic [PW-1:0] cmpsel_b,
  input  logic          rd_ack_a,
  input  logic          rd_ack_b,
  input  logic          cfg_merge,
  input  logic          cfg_odrain,
  input  logic          cfg_actlvl,
  output logic [PW-1:0] flag_a,
  output logic [PW-1:0] flag_b,
  output logic [PW-1:0] cap_a,
  output logic [PW-1:0] cap_b,
  output logic          irq_a_out,
  output logic          irq_a_oe,
  output logic          irq_b_out,
  output logic          irq_b_oe
);
  localparam int NP = pinchg_pkg::NPORT;

  logic [NP-1:0][PW-1:0] pin_v, ien_v, dflt_v, sel_v, flag_v, cap_v;
  logic [NP-1:0]         ack_v, pend_v, out_v, oe_v;
  pinchg_pkg::drv_cfg_t  cfg;

  assign pin_v  = {pin_b, pin_a};
  assign ien_v  = {ien_b, ien_a};
  assign dflt_v = {dflt_b, dflt_a};
  assign sel_v  = {cmpsel_b, cmpsel_a};
  assign ack_v  = {rd_ack_b, rd_ack_a};
  assign cfg    = '{merge: cfg_merge, odrain: cfg_odrain, actlvl: cfg_actlvl};

  for (genvar p = 0; p < NP; p++) begin : g_port
    pinchg_port #(.PW(PW)) u_port (
      .clk    (clk),
      .rst    (rst),
      .pin    (pin_v[p]),
      .ien    (ien_v[p]),
      .dflt   (dflt_v[p]),
      .cmpsel (sel_v[p]),
      .ack    (ack_v[p]),
      .pend   (pend_v[p]),
      .flag   (flag_v[p]),
      .cap    (cap_v[p])
    );
  end

  pinchg_drive #(.NP(NP)) u_drive (
    .clk  (clk),
    .rst  (rst),
    .cfg  (cfg),
    .pend (pend_v),
    .out  (out_v),
    .oe   (oe_v)
  );

  assign flag_a    = flag_v[0];
  assign flag_b    = flag_v[1];
  assign cap_a     = cap_v[0];
  assign cap_b     = cap_v[1];
  assign irq_a_out = out_v[0];
  assign irq_a_oe  = oe_v[0];
  assign irq_b_out = out_v[1];
  assign irq_b_oe  = oe_v[1];
endmodule

// File: rtl/pinchg_irq_chk.sv
module pinchg_irq_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] ien_a,
  input logic          rd_ack_a,
  input logic          rd_ack_b,
  input logic          cfg_merge,
  input logic          cfg_odrain,
  input logic [PW-1:0] flag_a,
  input logic [PW-1:0] flag_b,
  input logic [PW-1:0] cap_a,
  input logic [PW-1:0] cap_b,
  input logic          irq_a_out,
  input logic          irq_a_oe,
  input logic          irq_b_out,
  input logic          irq_b_oe
);
  AST_FREEZE_A: assert property (@(posedge clk) disable iff (rst)
    (|flag_a && !rd_ack_a) |=> ($stable(flag_a) && $stable(cap_a))); // R6
  AST_FREEZE_B: assert property (@(posedge clk) disable iff (rst)
    (|flag_b && !rd_ack_b) |=> ($stable(flag_b) && $stable(cap_b))); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|flag_a && rd_ack_a) |=> (flag_a == '0)); // R7
  AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((flag_a != '0) && ($past(flag_a) == '0)) |-> ((flag_a & ~$past(ien_a)) == '0)); // R4
  AST_MERGED_PINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_merge)) |-> (irq_a_out == irq_b_out && irq_a_oe == irq_b_oe)); // R9
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_odrain)) |-> (!irq_a_out && !irq_b_out)); // R11
  AST_PP_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_odrain)) |-> (irq_a_oe && irq_b_oe)); // R10
endmodule

bind pinchg_irq pinchg_irq_chk #(.PW(PW)) u_chk (.*);

// File: tb/sim_pinchg_irq.sv
`timescale 1ns/1ps
module sim_pinchg_irq;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [PW-1:0] pin_a, pin_b, ien_a, ien_b, dflt_a, dflt_b, cmpsel_a, cmpsel_b;
  logic rd_ack_a, rd_ack_b, cfg_merge, cfg_odrain, cfg_actlvl;
  logic [PW-1:0] flag_a, flag_b, cap_a, cap_b;
  logic irq_a_out, irq_a_oe, irq_b_out, irq_b_oe;

  int total = 0;
  int fails = 0;
  logic [PW-1:0] f_exp, cap_exp;
  logic act_a, act_b, pa, pb;

  always #4 clk = ~clk;

  pinchg_irq #(.PW(PW)) u0 (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1;
    pin_a = '0; pin_b = '0; ien_a = '0; ien_b = '0;
    dflt_a = '0; dflt_b = '0; cmpsel_a = '0; cmpsel_b = '0;
    rd_ack_a = 1'b0; rd_ack_b = 1'b0;
    cfg_merge = 1'b0; cfg_odrain = 1'b0; cfg_actlvl = 1'b1;
    cap_exp = '0;
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    chk("R1 flags", {flag_b, flag_a}, 0);
    chk("R1 caps", {cap_b, cap_a}, 0);
    chk("R1 pins", {irq_a_out, irq_a_oe, irq_b_out, irq_b_oe}, 0);
    rst = 1'b0;
    tick(); tick();

    // R2/R4/R5/R12: change-compare sweep on port A
    for (int k = 0; k < 256; k++) begin
      ien_a = PW'(k) ^ 8'h3C;
      pin_a = PW'(k);
      f_exp = PW'(k) & ien_a;
      tick();
      chk("R2 flag", flag_a, f_exp);
      if (f_exp != 0) cap_exp = PW'(k);
      chk("R5 capture", cap_a, cap_exp);
      chk("R12 pin lag", irq_a_out, 0);
      chk("R8 other port", flag_b, 0);
      tick();
      chk("R12 pin", irq_a_out, (f_exp != 0));
      rd_ack_a = 1'b1;
      tick();
      rd_ack_a = 1'b0;
      chk("R7 flag clear", flag_a, 0);
      chk("R7 capture kept", cap_a, cap_exp);
      ien_a = '0;
      pin_a = '0;
      tick();
      chk("R4 disabled", flag_a, 0);
    end

    // R3: default-compare sweep
    cmpsel_a = '1;
    for (int k = 0; k < 64; k++) begin
      ien_a = '0;
      dflt_a = PW'(k * 29);
      pin_a = PW'(k * 83);
      tick();
      ien_a = '1;
      f_exp = dflt_a ^ pin_a;
      tick();
      chk("R3 flag", flag_a, f_exp);
      if (f_exp != 0) begin
        cap_exp = pin_a;
        chk("R5 capture", cap_a, cap_exp);
        rd_ack_a = 1'b1;
        tick();
        rd_ack_a = 1'b0;
        chk("R7 clear", flag_a, 0);
        tick();
        chk("R3 refire", flag_a, f_exp);
        ien_a = '0;
        rd_ack_a = 1'b1;
        tick();
        rd_ack_a = 1'b0;
      end
      chk("R3 idle", flag_a, 0);
    end

    // R6/R7: freeze and idle acknowledge
    cmpsel_a = '0; ien_a = '0; pin_a = '0;
    tick();
    ien_a = '1;
    pin_a = 8'h01;
    tick();
    chk("R2 flag", flag_a, 8'h01);
    pin_a = 8'h82;
    tick();
    chk("R6 flag frozen", flag_a, 8'h01);
    chk("R6 capture frozen", cap_a, 8'h01);
    rd_ack_a = 1'b1;
    tick();
    chk("R7 clear", flag_a, 0);
    tick();
    chk("R7 idle ack flag", flag_a, 0);
    chk("R7 idle ack capture", cap_a, 8'h01);
    rd_ack_a = 1'b0;
    pin_a = 8'h80;
    tick();
    chk("R2 after idle ack", flag_a, 8'h02);
    chk("R5 capture", cap_a, 8'h80);
    rd_ack_a = 1'b1; ien_a = '0;
    tick();
    rd_ack_a = 1'b0;
    tick();

    // R8: port B alone
    ien_b = '1;
    pin_b = 8'h10;
    tick();
    chk("R8 flag b", flag_b, 8'h10);
    chk("R8 flag a", flag_a, 0);
    chk("R8 capture b", cap_b, 8'h10);
    tick();
    chk("R8 pin b", irq_b_out, 1);
    chk("R8 pin a", irq_a_out, 0);
    ien_b = '0; rd_ack_b = 1'b1;
    tick();
    rd_ack_b = 1'b0;

    // R9/R10/R11: drive configuration sweep
    cmpsel_a = '1; cmpsel_b = '1; dflt_a = '0; dflt_b = '0;
    pin_a = 8'h01; pin_b = 8'h01;
    for (int c = 0; c < 32; c++) begin
      cfg_merge = c[0]; cfg_odrain = c[1]; cfg_actlvl = c[2];
      pa = c[3]; pb = c[4];
      ien_a = {7'b0, pa}; ien_b = {7'b0, pb};
      rd_ack_a = 1'b1; rd_ack_b = 1'b1;
      tick();
      rd_ack_a = 1'b0; rd_ack_b = 1'b0;
      tick(); tick(); tick();
      act_a = cfg_merge ? (pa | pb) : pa;
      act_b = cfg_merge ? (pa | pb) : pb;
      if (cfg_odrain) begin
        chk("R11 out a", irq_a_out, 0);
        chk("R11 oe a", irq_a_oe, act_a);
        chk("R11 out b", irq_b_out, 0);
        chk("R11 oe b", irq_b_oe, act_b);
      end else begin
        chk(cfg_merge ? "R9 out a" : "R10 out a", irq_a_out, cfg_actlvl ? act_a : !act_a);
        chk("R10 oe a", irq_a_oe, 1);
        chk(cfg_merge ? "R9 out b" : "R10 out b", irq_b_out, cfg_actlvl ? act_b : !act_b);
        chk("R10 oe b", irq_b_oe, 1);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule